// File: doc/BRIEF.md
# Multi-Bit Unsigned Right Shifter

This block is a one-stage execution unit for a CPU with 20-bit registers. It takes a destination operand and a small immediate count (one to four positions) and shifts the value right. Zeros enter from the top of the active width, so the result is the operand divided by 2, 4, 8 or 16 with no rounding. The last bit shifted out becomes the carry. The unit also updates the negative, zero and overflow flags of the status register and copies every other status bit unchanged.

Two widths are supported. In address mode all 20 bits are shifted. In word mode only the low 16 bits are shifted, and the upper four bits of the result are written as zero. Each input accepted on `valid_i` produces a registered result and a new status word one clock later, marked by a single-cycle `valid_o` pulse.

Top module: `shr_unsigned_top`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `sr_o` and `valid_o` are all zero.
- R2: Each clock edge on which `valid_i` is high sets `valid_o` high for exactly the following cycle. `result_o` and `sr_o` carry that operation's values during this cycle.
- R3: When `valid_i` is low on an edge, `valid_o` is low after that edge. `result_o` and `sr_o` keep their previous values, whatever the other inputs do.
- R4: `count_i` encodes the shift distance n as n-1: 0 gives 1, 1 gives 2, 2 gives 3 and 3 gives 4. With `word_mode_i` low, `result_o` equals `operand_i >> n` over all 20 bits.
- R5: With `word_mode_i` high, `result_o[15:0]` equals `operand_i[15:0] >> n` and `result_o[19:16]` is zero. Input bits 19:16 have no effect.
- R6: The carry flag, status bit 0, is loaded with bit n-1 of the original operand.
- R7: The zero flag, status bit 1, is set when all 20 bits of `result_o` are zero and is cleared otherwise.
- R8: The negative flag, status bit 2, equals `result_o[19]` in address mode and `result_o[15]` in word mode.
- R9: The overflow flag, status bit 8, is always cleared.
- R10: Every status bit other than bits 0, 1, 2 and 8 is copied unchanged from `sr_i`. This covers the oscillator-off, CPU-off and interrupt-enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| operand_i | input | 20 | Destination operand |
| count_i | input | 2 | Shift count minus one |
| word_mode_i | input | 1 | 1 = 16-bit word mode, 0 = 20-bit address mode |
| sr_i | input | 16 | Current status register |
| result_o | output | 20 | Shifted result |
| valid_o | output | 1 | Result valid pulse |
| sr_o | output | 16 | Updated status register |

## Verification
All four counts are swept against both widths. The operands used are:
- Zero and all ones, which separate the zero-flag cases.
- A one walking through each of the 20 bit positions, which shows exactly where every input bit lands and which bit feeds the carry.
- Values with only bits 19:16 set, which must produce zero in word mode but not in address mode.
- A run of pseudo-random operands.

Status inputs of all zeros, all ones and alternating bits show that only the four flag positions move. Between operations the data inputs are changed with the strobe low, which tells holding apart from following the inputs.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int unsigned DATA_W = 20;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CNT_W  = 2;
  localparam int unsigned SR_W   = 16;

  localparam int unsigned MAX_N  = 1 << CNT_W;

  localparam int unsigned SR_C_BIT = 0;
  localparam int unsigned SR_Z_BIT = 1;
  localparam int unsigned SR_N_BIT = 2;
  localparam int unsigned SR_V_BIT = 8;

  localparam logic [SR_W-1:0] SR_FLAG_MASK =
    (SR_W'(1) << SR_C_BIT) | (SR_W'(1) << SR_Z_BIT) |
    (SR_W'(1) << SR_N_BIT) | (SR_W'(1) << SR_V_BIT);

  typedef struct packed {
    logic [DATA_W-1:0] result;
    logic              carry;
  } shr_res_t;
endpackage

// File: rtl/shr_core.sv
module shr_core
  import shr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned WW = WORD_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic [DW-1:0] operand_i,
  input  logic [CW-1:0] count_i,
  input  logic          word_mode_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o
);
  localparam int unsigned NC = 1 << CW;

  logic [DW-1:0] src;
  logic [DW-1:0] cand_res [NC];
  logic          cand_c   [NC];

  // word mode: upper bits dropped before shifting so zeros fill from bit WW-1
  assign src = word_mode_i ? {{(DW-WW){1'b0}}, operand_i[WW-1:0]} : operand_i;

  for (genvar g = 0; g < NC; g++) begin : g_dist
    assign cand_res[g] = src >> (g + 1);
    assign cand_c[g]   = src[g];
  end

  assign result_o = cand_res[count_i];
  assign carry_o  = cand_c[count_i];
endmodule

// File: rtl/shr_flags.sv
module shr_flags
  import shr_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned WW = WORD_W,
  parameter int unsigned SW = SR_W
) (
  input  logic [DW-1:0] result_i,
  input  logic          carry_i,
  input  logic          word_mode_i,
  input  logic [SW-1:0] sr_i,
  output logic [SW-1:0] sr_o
);
  logic neg;
  logic zero;

  assign neg  = word_mode_i ? result_i[WW-1] : result_i[DW-1];
  assign zero = (result_i == '0);

  always_comb begin
    sr_o           = sr_i;
    sr_o[SR_C_BIT] = carry_i;
    sr_o[SR_Z_BIT] = zero;
    sr_o[SR_N_BIT] = neg;
    sr_o[SR_V_BIT] = 1'b0;
  end
endmodule

// File: rtl/shr_unsigned_top.sv
module shr_unsigned_top
  import shr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              word_mode_i,
  input  logic [SR_W-1:0]   sr_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic [SR_W-1:0]   sr_o
);
  shr_res_t        res_d;
  logic [SR_W-1:0] sr_d;

  shr_core #(.DW(DATA_W), .WW(WORD_W), .CW(CNT_W)) i_core (
    .operand_i   (operand_i),
    .count_i     (count_i),
    .word_mode_i (word_mode_i),
    .result_o    (res_d.result),
    .carry_o     (res_d.carry)
  );

  shr_flags #(.DW(DATA_W), .WW(WORD_W), .SW(SR_W)) i_flags (
    .result_i    (res_d.result),
    .carry_i     (res_d.carry),
    .word_mode_i (word_mode_i),
    .sr_i        (sr_i),
    .sr_o        (sr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      sr_o     <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d.result;
        sr_o     <= sr_d;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(result_o) && $stable(sr_o))); // R3
  AST_WORD_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && word_mode_i) |=> (result_o[DATA_W-1:WORD_W] == '0)); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sr_o[SR_Z_BIT] == (result_o == '0))); // R7
  AST_NEG_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (sr_o[SR_N_BIT] ==
                 ($past(word_mode_i) ? result_o[WORD_W-1] : result_o[DATA_W-1]))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !sr_o[SR_V_BIT]); // R9
  AST_SR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ((sr_o & ~SR_FLAG_MASK) == ($past(sr_i) & ~SR_FLAG_MASK))); // R10
endmodule

// File: tb/test_shr_unsigned_top.sv
module test_shr_unsigned_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [19:0] operand_i = '0;
  logic [1:0]  count_i = '0;
  logic        word_mode_i = 1'b0;
  logic [15:0] sr_i = '0;
  logic [19:0] result_o;
  logic        valid_o;
  logic [15:0] sr_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  shr_unsigned_top i_shr_unsigned_top (
    .clk_i, .rst_ni, .valid_i, .operand_i, .count_i, .word_mode_i, .sr_i,
    .result_o, .valid_o, .sr_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [19:0] op, input int cnt, input logic wm,
                        input logic [15:0] sr);
    int n;
    logic [19:0] src, exp_res;
    logic [15:0] exp_sr;
    n = cnt + 1;
    src = wm ? {4'h0, op[15:0]} : op;
    exp_res = src >> n;
    exp_sr = sr;
    exp_sr[0] = op[n-1];
    exp_sr[1] = (exp_res == 20'h0);
    exp_sr[2] = wm ? exp_res[15] : exp_res[19];
    exp_sr[8] = 1'b0;
    @(negedge clk_i);
    valid_i = 1'b1; operand_i = op; count_i = 2'(cnt); word_mode_i = wm; sr_i = sr;
    @(negedge clk_i);
    valid_i = 1'b0;
    operand_i = ~op; count_i = ~2'(cnt); word_mode_i = ~wm; sr_i = ~sr;
    chk("R2 valid", 32'(valid_o), 32'd1);
    if (wm) chk("R5 word result", 32'(result_o), 32'(exp_res));
    else    chk("R4 addr result", 32'(result_o), 32'(exp_res));
    chk("R6 carry", 32'(sr_o[0]), 32'(exp_sr[0]));
    chk("R7 zero", 32'(sr_o[1]), 32'(exp_sr[1]));
    chk("R8 neg", 32'(sr_o[2]), 32'(exp_sr[2]));
    chk("R9 ovf", 32'(sr_o[8]), 32'd0);
    chk("R10 sr pass", 32'(sr_o), 32'(exp_sr));
    @(negedge clk_i);
    chk("R3 valid low", 32'(valid_o), 32'd0);
    chk("R3 hold result", 32'(result_o), 32'(exp_res));
    chk("R3 hold sr", 32'(sr_o), 32'(exp_sr));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] srs [3];
    srs[0] = 16'h0000; srs[1] = 16'hFFFF; srs[2] = 16'hA5A5;
    repeat (3) @(negedge clk_i);
    chk("R1 reset result", 32'(result_o), 32'd0);
    chk("R1 reset sr", 32'(sr_o), 32'd0);
    chk("R1 reset valid", 32'(valid_o), 32'd0);
    rst_ni = 1'b1;
    for (int wm = 0; wm < 2; wm++) begin
      for (int c = 0; c < 4; c++) begin
        for (int s = 0; s < 3; s++) begin
          run_op(20'h00000, c, wm[0], srs[s]);
          run_op(20'hFFFFF, c, wm[0], srs[s]);
          run_op(20'hF0000, c, wm[0], srs[s]);
          run_op(20'h80000, c, wm[0], srs[s]);
        end
        for (int b = 0; b < 20; b++) run_op(20'h1 << b, c, wm[0], srs[b % 3]);
        for (int r = 0; r < 24; r++) begin
          lfsr = lfsr * 32'd1664525 + 32'd1013904223;
          run_op(lfsr[27:8], c, wm[0], lfsr[15:0]);
        end
      end
    end
    // back-to-back strobes: second op must appear the very next cycle
    @(negedge clk_i);
    valid_i = 1'b1; operand_i = 20'h00010; count_i = 2'd3; word_mode_i = 1'b0; sr_i = 16'h0000;
    @(negedge clk_i);
    operand_i = 20'h00003; count_i = 2'd0;
    chk("R4 b2b first", 32'(result_o), 32'h1);
    @(negedge clk_i);
    valid_i = 1'b0;
    chk("R2 b2b valid", 32'(valid_o), 32'd1);
    chk("R4 b2b second", 32'(result_o), 32'h1);
    chk("R6 b2b carry", 32'(sr_o[0]), 32'd1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset result", 32'(result_o), 32'd0);
    chk("R1 async reset valid", 32'(valid_o), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule